// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Pair

This unit serves a 32-bit integer core as its multiply and divide engine. It keeps results in a private register pair, HI and LO, outside the general register file. Arithmetic requests take two 32-bit operands. Each one runs for a fixed number of cycles, one bit per cycle, with the block showing busy the whole time. The multiply uses a shift-add loop and the divide uses a restoring loop. Signed requests are handled by working on magnitudes and correcting the signs when the loop ends.

The core reads HI or LO through move-from requests. These copy the selected register onto a 32-bit result port for writeback. Move-to requests load an operand into HI or LO directly. A move-from issued while an operation is still running is held with a stall indication until the new HI/LO values are in place. A new arithmetic request that arrives while the unit is busy is dropped.

Top module: `muldiv_hilo`

## Requirements
- R1: After reset, HI and LO both read 0, busy and stall are low, and res_valid is low.
- R2: Unsigned multiply (op_code 2) forms the full 64-bit product of src_a and src_b. LO receives bits 31:0 and HI receives bits 63:32.
- R3: Signed multiply (op_code 1) forms the 64-bit two's-complement product and splits it between LO and HI in the same way as R2.
- R4: Unsigned divide (op_code 4) with a nonzero divisor src_b places the quotient src_a/src_b in LO and the remainder in HI.
- R5: Signed divide (op_code 3) rounds the quotient toward zero, and the remainder carries the sign of the dividend. 0x80000000 divided by 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R6: A divide with src_b equal to zero, signed or unsigned, completes normally. LO becomes 0xFFFFFFFF and HI becomes the original dividend src_a.
- R7: busy rises on the clock edge that accepts an arithmetic request and stays high for exactly 32 cycles. HI and LO are updated on the same edge at which busy falls, and they hold steady before that edge.
- R8: An arithmetic request (op_code 1 to 4) or a move-to request made while busy is ignored. It neither alters the result of the running operation nor starts another one.
- R9: A move-from request made while idle (op_code 5 reads HI, op_code 6 reads LO) raises res_valid in the same cycle, with res_data equal to the selected register.
- R10: A move-from request made while busy raises stall and keeps res_valid low. Once busy drops, the same held request returns the newly written value.
- R11: While idle, a move-to request (op_code 7 for HI, op_code 8 for LO) writes src_a into the selected register at the next edge and leaves the other register unchanged.
- R12: op_code 0 is a no-operation, and requests are only acted on while op_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | A request is present on op_code and the operand inputs |
| op_code | input | 4 | Request code (see R2 to R12) |
| src_a | input | 32 | First operand: multiplicand, dividend, or value for a move-to |
| src_b | input | 32 | Second operand: multiplier or divisor |
| busy | output | 1 | An arithmetic operation is running |
| stall | output | 1 | A move-from request is being held because the unit is busy |
| res_valid | output | 1 | res_data carries the result of a move-from |
| res_data | output | 32 | HI or LO contents for writeback |

## Verification
The bench targets the sign corners. These are the largest negative value, operands of mixed sign, and 0x80000000 divided by minus one. A unit that got the sign correction wrong would return the remainder with the divisor's sign, or round the quotient toward minus infinity. Divide by zero is sent with dividends of both signs. This catches a design that lets the sign fix-up corrupt the all-ones quotient or the dividend returned in HI. The bench also holds a move-from across a whole busy period and sends starts and move-to requests mid-operation. A design that released the read early would hand back stale HI/LO. One that accepted late requests would corrupt the result or stretch the busy window beyond 32 cycles.

// File: rtl/muldiv_pkg.sv
`timescale 1ns/1ps
package muldiv_pkg;

    typedef enum logic [3:0] {
        MD_NOP  = 4'd0,
        MD_MULS = 4'd1,
        MD_MULU = 4'd2,
        MD_DIVS = 4'd3,
        MD_DIVU = 4'd4,
        MD_MFHI = 4'd5,
        MD_MFLO = 4'd6,
        MD_MTHI = 4'd7,
        MD_MTLO = 4'd8
    } md_op_e;

    function automatic logic op_is_arith(md_op_e op);
        return (op == MD_MULS) || (op == MD_MULU) || (op == MD_DIVS) || (op == MD_DIVU);
    endfunction

    function automatic logic op_is_read(md_op_e op);
        return (op == MD_MFHI) || (op == MD_MFLO);
    endfunction

endpackage

// File: rtl/muldiv_prep.sv
`timescale 1ns/1ps
// Operand conditioning: magnitudes and sign bookkeeping for signed requests.
module muldiv_prep #(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         is_signed,
    input  logic         is_div,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg_main,
    output logic         neg_rem,
    output logic         div_zero
);
    logic neg_a;
    logic neg_b;

    always_comb begin
        neg_a    = is_signed & opa[W-1];
        neg_b    = is_signed & opb[W-1];
        mag_a    = neg_a ? (~opa + 1'b1) : opa;
        mag_b    = neg_b ? (~opb + 1'b1) : opb;
        neg_main = neg_a ^ neg_b;
        neg_rem  = neg_a;
        div_zero = is_div & (opb == '0);
    end
endmodule

// File: rtl/muldiv_step.sv
`timescale 1ns/1ps
// One iteration: shift-add multiply or restoring divide on a 2W-bit work register.
module muldiv_step #(
    parameter int W = 32
) (
    input  logic           is_div,
    input  logic [2*W-1:0] work,
    input  logic [W-1:0]   opnd,
    output logic [2*W-1:0] work_nxt
);
    logic [W:0] sum;
    logic [W:0] shifted;
    logic [W:0] diff;

    always_comb begin
        // multiply: conditionally add multiplicand into upper half, then shift right
        sum     = {1'b0, work[2*W-1:W]} + (work[0] ? {1'b0, opnd} : '0);
        // divide: shift next dividend bit into partial remainder, trial subtract
        shifted = work[2*W-1:W-1];
        diff    = shifted - {1'b0, opnd};
        if (!is_div) begin
            work_nxt = {sum, work[W-1:1]};
        end else if (!diff[W]) begin
            work_nxt = {diff[W-1:0], work[W-2:0], 1'b1};
        end else begin
            work_nxt = {shifted[W-1:0], work[W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/muldiv_fixup.sv
`timescale 1ns/1ps
// Final sign correction and HI/LO placement.
module muldiv_fixup #(
    parameter int W = 32
) (
    input  logic           is_div,
    input  logic           neg_main,
    input  logic           neg_rem,
    input  logic           div_zero,
    input  logic [2*W-1:0] work,
    output logic [W-1:0]   hi_new,
    output logic [W-1:0]   lo_new
);
    logic [2*W-1:0] prod;
    logic [W-1:0]   quo;
    logic [W-1:0]   rem;

    always_comb begin
        prod = neg_main ? (~work + 1'b1) : work;
        quo  = work[W-1:0];
        rem  = work[2*W-1:W];
        if (is_div) begin
            lo_new = div_zero ? '1 : (neg_main ? (~quo + 1'b1) : quo);
            hi_new = neg_rem ? (~rem + 1'b1) : rem;
        end else begin
            lo_new = prod[W-1:0];
            hi_new = prod[2*W-1:W];
        end
    end
endmodule

// File: rtl/muldiv_hilo.sv
`timescale 1ns/1ps
module muldiv_hilo
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_valid,
    input  logic [3:0]   op_code,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    output logic         busy,
    output logic         stall,
    output logic         res_valid,
    output logic [W-1:0] res_data
);
    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             is_div;
        logic             neg_main;
        logic             neg_rem;
        logic             div_zero;
        logic [W-1:0]     opnd;
        logic [2*W-1:0]   work;
        logic [W-1:0]     hi;
        logic [W-1:0]     lo;
    } state_t;

    state_t st_q, st_d;

    md_op_e         op;
    logic           req_arith;
    logic           req_read;
    logic           req_signed;
    logic           req_div;
    logic [W-1:0]   mag_a, mag_b;
    logic           p_neg_main, p_neg_rem, p_div_zero;
    logic [2*W-1:0] step_nxt;
    logic [W-1:0]   fix_hi, fix_lo;

    always_comb begin
        op         = md_op_e'(op_code);
        req_arith  = op_valid && op_is_arith(op);
        req_read   = op_valid && op_is_read(op);
        req_signed = (op == MD_MULS) || (op == MD_DIVS);
        req_div    = (op == MD_DIVS) || (op == MD_DIVU);
    end

    muldiv_prep #(.W(W)) u_prep (
        .opa       (src_a),
        .opb       (src_b),
        .is_signed (req_signed),
        .is_div    (req_div),
        .mag_a     (mag_a),
        .mag_b     (mag_b),
        .neg_main  (p_neg_main),
        .neg_rem   (p_neg_rem),
        .div_zero  (p_div_zero)
    );

    muldiv_step #(.W(W)) u_step (
        .is_div   (st_q.is_div),
        .work     (st_q.work),
        .opnd     (st_q.opnd),
        .work_nxt (step_nxt)
    );

    muldiv_fixup #(.W(W)) u_fix (
        .is_div   (st_q.is_div),
        .neg_main (st_q.neg_main),
        .neg_rem  (st_q.neg_rem),
        .div_zero (st_q.div_zero),
        .work     (step_nxt),
        .hi_new   (fix_hi),
        .lo_new   (fix_lo)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (req_arith) begin
                st_d.busy     = 1'b1;
                st_d.cnt      = '0;
                st_d.is_div   = req_div;
                st_d.neg_main = p_neg_main;
                st_d.neg_rem  = req_div & p_neg_rem;
                st_d.div_zero = p_div_zero;
                st_d.opnd     = req_div ? mag_b : mag_a;
                st_d.work     = {{W{1'b0}}, (req_div ? mag_a : mag_b)};
            end else if (op_valid && op == MD_MTHI) begin
                st_d.hi = src_a;
            end else if (op_valid && op == MD_MTLO) begin
                st_d.lo = src_a;
            end
        end else begin
            st_d.work = step_nxt;
            st_d.cnt  = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.hi   = fix_hi;
                st_d.lo   = fix_lo;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        busy      = st_q.busy;
        stall     = req_read && st_q.busy;
        res_valid = req_read && !st_q.busy;
        res_data  = '0;
        if (res_valid) begin
            res_data = (op == MD_MFHI) ? st_q.hi : st_q.lo;
        end
    end

    // R7: accepted request starts the busy window
    a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (req_arith && !busy) |=> busy);

    // R7: busy holds until the final iteration, then drops
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.cnt != LAST) |=> busy);

    a_r7_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.cnt == LAST) |=> !busy);

    // R7: HI/LO untouched before the completing edge
    a_r7_hilo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.cnt != LAST) |=> ($stable(st_q.hi) && $stable(st_q.lo)));

    // R8: requests during busy leave the captured operand alone
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_valid) |=> ($stable(st_q.opnd) && $stable(st_q.is_div)));

    // R6: divide by zero completes with LO all ones
    a_r6_div0_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q.cnt == LAST && st_q.is_div && st_q.div_zero) |=> (st_q.lo == '1));

    // R11: move-to HI writes the operand
    a_r11_move_to_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op == MD_MTHI && !busy) |=> (st_q.hi == $past(src_a)));

    // R10: a held read never reports a result
    a_r10_stall_no_result: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !res_valid);

endmodule

// File: tb/tb_muldiv_hilo.sv
`timescale 1ns/1ps
module tb_muldiv_hilo;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        busy, stall, res_valid;
    logic [31:0] res_data;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [3:0] C_MULS = 4'd1, C_MULU = 4'd2, C_DIVS = 4'd3, C_DIVU = 4'd4,
                           C_MFHI = 4'd5, C_MFLO = 4'd6, C_MTHI = 4'd7, C_MTLO = 4'd8;

    always #4 clk = ~clk;

    muldiv_hilo dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .src_a(src_a), .src_b(src_b), .busy(busy), .stall(stall),
        .res_valid(res_valid), .res_data(res_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // returns {hi, lo}
    function automatic logic [63:0] model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        logic [63:0] ua, ub;
        longint sa, sb, q, r;
        ua = {32'b0, a};
        ub = {32'b0, b};
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (op)
            C_MULU: return ua * ub;
            C_MULS: return 64'(sa * sb);
            C_DIVU: begin
                if (b == 0) return {a, 32'hFFFF_FFFF};
                return {a % b, a / b};
            end
            default: begin
                if (b == 0) return {a, 32'hFFFF_FFFF};
                q = sa / sb;
                r = sa % sb;
                return {r[31:0], q[31:0]};
            end
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op, input logic [31:0] b);
        if ((op == C_DIVU || op == C_DIVS) && b == 0) return "R6";
        case (op)
            C_MULU: return "R2";
            C_MULS: return "R3";
            C_DIVU: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic read_reg(input logic [3:0] op, output logic [31:0] d, output logic v);
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = op;
        #1;
        v = res_valid;
        d = res_data;
        op_valid = 1'b0;
        op_code  = 4'd0;
    endtask

    task automatic run_arith(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                             output int cycles);
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = op;
        src_a    = a;
        src_b    = b;
        @(negedge clk);
        op_valid = 1'b0;
        op_code  = 4'd0;
        cycles = 0;
        while (busy) begin
            cycles++;
            @(negedge clk);
        end
    endtask

    task automatic check_arith(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b);
        int cyc;
        logic [63:0] exp;
        logic [31:0] d;
        logic v;
        string rq;
        exp = model(op, a, b);
        rq  = req_of(op, b);
        run_arith(op, a, b, cyc);
        chk("R7 busy length", 32'(cyc), 32'd32);
        read_reg(C_MFHI, d, v);
        chk({rq, " HI"}, d, exp[63:32]);
        read_reg(C_MFLO, d, v);
        chk({rq, " LO"}, d, exp[31:0]);
    endtask

    initial begin
        #(8 * 150000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic v;
        int viol;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 res_valid idle", {31'b0, res_valid}, 32'd0);
        read_reg(C_MFHI, d, v);
        chk("R1 HI", d, 32'd0);
        chk("R9 res_valid", {31'b0, v}, 32'd1);
        read_reg(C_MFLO, d, v);
        chk("R1 LO", d, 32'd0);

        // R11 move-to, other register unchanged
        @(negedge clk); op_valid = 1; op_code = C_MTHI; src_a = 32'h1234_5678;
        @(negedge clk); op_code = C_MTLO; src_a = 32'h9ABC_DEF0;
        @(negedge clk); op_valid = 0; op_code = 0;
        read_reg(C_MFHI, d, v);
        chk("R11 HI after MTLO", d, 32'h1234_5678);
        read_reg(C_MFLO, d, v);
        chk("R11 LO", d, 32'h9ABC_DEF0);

        // R12 op_valid low ignored; NOP ignored
        @(negedge clk); op_valid = 0; op_code = C_MTHI; src_a = 32'hFFFF_0000;
        @(negedge clk); op_valid = 1; op_code = 4'd0;
        @(negedge clk); #1;
        chk("R12 NOP no busy", {31'b0, busy}, 32'd0);
        chk("R12 NOP no result", {31'b0, res_valid}, 32'd0);
        op_valid = 0;
        read_reg(C_MFHI, d, v);
        chk("R12 HI unchanged", d, 32'h1234_5678);

        // Directed corners
        check_arith(C_MULU, 32'hFFFF_FFFF, 32'hFFFF_FFFF); // R2 fffffffe_00000001
        check_arith(C_MULS, 32'h8000_0000, 32'h8000_0000); // R3 40000000_00000000
        check_arith(C_MULS, 32'hFFFF_FFFF, 32'd1);         // R3 all ones
        check_arith(C_MULS, 32'hFFFF_FFFD, 32'd7);         // R3 -21
        check_arith(C_DIVU, 32'hFFFF_FFFF, 32'd10);        // R4
        check_arith(C_DIVS, 32'hFFFF_FFF9, 32'd2);         // R5 q -3 r -1
        check_arith(C_DIVS, 32'd7, 32'hFFFF_FFFE);         // R5 q -3 r 1
        check_arith(C_DIVS, 32'h8000_0000, 32'hFFFF_FFFF); // R5 q 80000000 r 0
        check_arith(C_DIVU, 32'hDEAD_BEEF, 32'd0);         // R6
        check_arith(C_DIVS, 32'h8000_0005, 32'd0);         // R6 negative dividend

        // R8: requests during busy ignored
        @(negedge clk); op_valid = 1; op_code = C_MULU; src_a = 32'd3; src_b = 32'd5;
        @(negedge clk); op_code = C_DIVU; src_a = 32'd100; src_b = 32'd7;
        @(negedge clk); op_code = C_MTHI; src_a = 32'hDEAD_0000;
        @(negedge clk); op_code = C_MTLO;
        @(negedge clk); op_valid = 0; op_code = 0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk("R8 no restart", {31'b0, busy}, 32'd0);
        read_reg(C_MFHI, d, v);
        chk("R8 HI", d, 32'd0);
        read_reg(C_MFLO, d, v);
        chk("R8 LO", d, 32'd15);

        // R10: held read across busy
        @(negedge clk); op_valid = 1; op_code = C_DIVU; src_a = 32'd1000; src_b = 32'd7;
        @(negedge clk); op_code = C_MFLO;
        viol = 0;
        #1;
        chk("R10 stall raised", {31'b0, stall}, 32'd1);
        while (busy) begin
            if (!stall || res_valid) viol++;
            @(negedge clk); #1;
        end
        chk("R10 stall held", 32'(viol), 32'd0);
        chk("R10 released", {31'b0, res_valid}, 32'd1);
        chk("R10 new LO", res_data, 32'd142);
        op_valid = 0; op_code = 0;

        // Random mix
        for (int i = 0; i < 60; i++) begin
            logic [3:0] op;
            logic [31:0] a, b;
            op = 4'(1 + ($urandom % 4));
            a  = $urandom;
            b  = $urandom;
            case ($urandom % 8)
                0: b = 32'd0;
                1: b = $urandom % 16;
                2: a = 32'h8000_0000;
                default: ;
            endcase
            check_arith(op, a, b);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule